// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

This block is one timer channel built around a single 16-bit value register. A 4-bit mode field selects what that register does. In capture modes it records the count of a free-running 16-bit timebase when the capture input changes. In compare modes it holds a target, and the channel reacts when the timebase reaches that target. In PWM modes it holds the upper part of a 10-bit duty cycle, and the channel produces a pulse train that follows an external 8-bit period timebase.

Software reaches the channel through a small byte-wide port with three registers: control, value low byte and value high byte. The channel drives one output pin, an interrupt flag and a one-cycle trigger pulse. The flag is cleared by pulsing a strobe input. Both timebases come from outside the block.

Top module: `ccp_channel`

## Requirements
- R1: After synchronous reset, every register reads 0, and `pin_out`, `irq_flag` and `sev_trig` are low.
- R2: Register map. Address 0 is control, read as {2'b00, duty_lsb[1:0], mode[3:0]}, with duty_lsb at bits 5:4 and mode at bits 3:0. Bits 7:6 always read 0. Address 1 is value[7:0], address 2 is value[15:8], and address 3 reads 0. A write takes effect on the next clock.
- R3: Mode codes 0000, 0001 and 0011 disable the channel. The pin stays low, no capture or match sets the flag, no trigger is emitted, and the edge prescaler is cleared.
- R4: Mode 0101 captures on each rising edge and mode 0100 on each falling edge of `cap_in`. The input is seen through a two-flop synchronizer. A capture copies `tb_count` into the value register and sets `irq_flag`. The edge that is not selected has no effect.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Any change of the mode code restarts the edge count from zero.
- R6: Mode 0010 toggles the pin on each compare match and sets the flag.
- R7: Writing mode 1000 drives the pin low, and a match then forces it high. Writing mode 1001 drives the pin high, and a match then forces it low. Both set the flag on a match.
- R8: Mode 1010 sets only the flag on a match and leaves the pin unchanged. Mode 1011 sets the flag and raises `sev_trig` for exactly one cycle.
- R9: A match occurs only on the first cycle that `tb_count` equals the value register. Holding that count produces no further matches.
- R10: Codes 11xx select PWM. The duty is {value[7:0], duty_lsb}. When `pwm_period_start` is high, the pin is set high and the duty is latched. The pin falls after the cycle in which {`pwm_count`, 2-bit fine phase} equals the latched duty. The fine phase restarts at 1 on the cycle after a period start, so a period shows the pin high for exactly `duty` cycles (capped at the period length). A duty written mid-period applies from the next period.
- R11: A latched duty of 0 keeps the pin low for the whole period.
- R12: `flag_clr` clears `irq_flag`. If a capture or match happens in the same cycle, setting the flag wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| flag_clr | input | 1 | Clears the interrupt flag |
| tb_count | input | 16 | Capture/compare timebase count |
| pwm_count | input | 8 | PWM timebase count |
| pwm_period_start | input | 1 | High on the first cycle of a PWM period |
| cap_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Channel output pin |
| irq_flag | output | 1 | Interrupt flag |
| sev_trig | output | 1 | One-cycle special-event trigger |

## Verification
A capture shows up three clocks after `cap_in` changes: two synchronizer flops, then the edge-history flop feeding the value register. The bench holds each level for three cycles and reads the value register at the falling edge that follows. Compare results (pin, flag, trigger) and register writes land on the first clock after the stimulus, so the bench checks them one falling edge later. For PWM, the bench drives the period timebase itself and counts high samples over a whole 64-cycle period. The pin registered on each cycle is sampled at the next falling edge, so the expected count is simply the duty, capped at the period length.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    parameter int TB_W    = 16;
    parameter int DATA_W  = 8;
    parameter int PWM_W   = 8;
    parameter int FINE_W  = 2;
    parameter int ADDR_W  = 2;
    parameter int MODE_W  = 4;
    parameter int SYNC_N  = 2;
    parameter int PRE_W   = 4;

    localparam int DUTY_W = PWM_W + FINE_W;
    localparam int CTRL_W = FINE_W + MODE_W;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_VLO  = 2'd1;
    localparam logic [ADDR_W-1:0] A_VHI  = 2'd2;

    localparam logic [MODE_W-1:0] M_TOGGLE = 4'b0010;
    localparam logic [MODE_W-1:0] M_SET_HI = 4'b1000;
    localparam logic [MODE_W-1:0] M_SET_LO = 4'b1001;
    localparam logic [MODE_W-1:0] M_FLAG   = 4'b1010;
    localparam logic [MODE_W-1:0] M_TRIG   = 4'b1011;

    typedef enum logic [1:0] {K_OFF, K_CAP, K_CMP, K_PWM} kind_e;

    typedef struct packed {
        logic [FINE_W-1:0] duty_lo;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    function automatic kind_e mode_kind(input logic [MODE_W-1:0] m);
        kind_e k;
        casez (m)
            4'b11??: k = K_PWM;
            4'b01??: k = K_CAP;
            4'b10??: k = K_CMP;
            4'b0010: k = K_CMP;
            default: k = K_OFF;
        endcase
        return k;
    endfunction

    function automatic logic [PRE_W-1:0] prescale_last(input logic [1:0] sel);
        logic [PRE_W-1:0] r;
        case (sel)
            2'b10:   r = PRE_W'(3);
            2'b11:   r = PRE_W'(15);
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ccp_capture.sv
module ccp_capture
    import ccp_pkg::*;
#(
    parameter int STAGES = SYNC_N,
    parameter int PCW    = PRE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       restart,
    input  logic [1:0] sel,
    input  logic       cap_in,
    output logic       cap_stb
);
    logic [STAGES:0]  sh_q;
    logic [PCW-1:0]   pcnt_q;
    logic             rise, fall, hit;
    logic [PCW-1:0]   last;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], cap_in};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    assign last = PCW'(prescale_last(sel));

    always_comb begin
        case (sel)
            2'b00:   hit = fall;
            2'b01:   hit = rise;
            default: hit = rise && (pcnt_q == last);
        endcase
    end

    assign cap_stb = enable && hit;

    always_ff @(posedge clk) begin
        if (rst || !enable || restart) begin
            pcnt_q <= '0;
        end else if (sel[1] && rise) begin
            pcnt_q <= (pcnt_q == last) ? '0 : pcnt_q + PCW'(1);
        end
    end

    // R5
    prescale_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !restart && sel == 2'b10) |=> (pcnt_q <= PCW'(3)));
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
    import ccp_pkg::*;
#(
    parameter int W = TB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [MODE_W-1:0] mode,
    input  logic              enter,
    input  logic [MODE_W-1:0] enter_mode,
    input  logic [W-1:0]      count,
    input  logic [W-1:0]      value,
    output logic              match,
    output logic              pin_q,
    output logic              trig_q
);
    logic eq, eq_q;

    assign eq = (count == value);

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b0;
        else     eq_q <= eq;
    end

    assign match = enable && eq && !eq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else if (enter && enter_mode == M_SET_HI) begin
            pin_q <= 1'b0;
        end else if (enter && enter_mode == M_SET_LO) begin
            pin_q <= 1'b1;
        end else if (!enable) begin
            pin_q <= 1'b0;
        end else if (match) begin
            case (mode)
                M_TOGGLE: pin_q <= ~pin_q;
                M_SET_HI: pin_q <= 1'b1;
                M_SET_LO: pin_q <= 1'b0;
                default:  pin_q <= pin_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= match && (mode == M_TRIG);
    end

    // R9
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        match |=> !match);
    // R8
    trig_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trig_q |=> !trig_q);
    // R7
    force_high_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !enter && mode == M_SET_HI && match) |=> pin_q);
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm
    import ccp_pkg::*;
#(
    parameter int CW = PWM_W,
    parameter int FW = FINE_W,
    localparam int DW = CW + FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          period_start,
    input  logic [CW-1:0] count,
    input  logic [DW-1:0] duty_in,
    output logic          pin_q
);
    logic [FW-1:0] fine_q;
    logic [DW-1:0] duty_q;
    logic [DW-1:0] phase;

    assign phase = {count, fine_q};

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pin_q  <= 1'b0;
            fine_q <= '0;
            duty_q <= '0;
        end else begin
            fine_q <= period_start ? FW'(1) : fine_q + FW'(1);
            if (period_start) begin
                duty_q <= duty_in;
                pin_q  <= (duty_in != '0);
            end else if (phase == duty_q) begin
                pin_q  <= 1'b0;
            end
        end
    end

    // R11
    duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && period_start && duty_in == '0) |=> !pin_q);
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
    import ccp_pkg::*;
#(
    parameter int T_W = TB_W,
    parameter int D_W = DATA_W,
    parameter int P_W = PWM_W,
    parameter int A_W = ADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [A_W-1:0] wr_addr,
    input  logic [D_W-1:0] wr_data,
    input  logic [A_W-1:0] rd_addr,
    output logic [D_W-1:0] rd_data,
    input  logic           flag_clr,
    input  logic [T_W-1:0] tb_count,
    input  logic [P_W-1:0] pwm_count,
    input  logic           pwm_period_start,
    input  logic           cap_in,
    output logic           pin_out,
    output logic           irq_flag,
    output logic           sev_trig
);
    localparam int HI_W = T_W - D_W;

    ctrl_t             ctrl_q;
    logic [T_W-1:0]    val_q;
    kind_e             kind;
    logic              ctrl_wr, mode_chg;
    logic [MODE_W-1:0] new_mode;
    logic              cap_stb, cmp_match, cmp_pin, cmp_trig, pwm_pin;
    logic              flag_set, flag_q;
    logic [P_W+FINE_W-1:0] duty_in;

    assign kind     = mode_kind(ctrl_q.mode);
    assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    assign new_mode = wr_data[MODE_W-1:0];
    assign mode_chg = ctrl_wr && (new_mode != ctrl_q.mode);
    assign duty_in  = {val_q[P_W-1:0], ctrl_q.duty_lo};

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (cap_stb) begin
            val_q <= tb_count;
        end else if (wr_en && wr_addr == A_VLO) begin
            val_q[D_W-1:0] <= wr_data;
        end else if (wr_en && wr_addr == A_VHI) begin
            val_q[T_W-1:D_W] <= wr_data[HI_W-1:0];
        end
    end

    ccp_capture #(.STAGES(SYNC_N), .PCW(PRE_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .enable  (kind == K_CAP),
        .restart (mode_chg),
        .sel     (ctrl_q.mode[1:0]),
        .cap_in  (cap_in),
        .cap_stb (cap_stb)
    );

    ccp_compare #(.W(T_W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .enable     (kind == K_CMP),
        .mode       (ctrl_q.mode),
        .enter      (mode_chg),
        .enter_mode (new_mode),
        .count      (tb_count),
        .value      (val_q),
        .match      (cmp_match),
        .pin_q      (cmp_pin),
        .trig_q     (cmp_trig)
    );

    ccp_pwm #(.CW(P_W), .FW(FINE_W)) u_pwm (
        .clk          (clk),
        .rst          (rst),
        .enable       (kind == K_PWM),
        .period_start (pwm_period_start),
        .count        (pwm_count),
        .duty_in      (duty_in),
        .pin_q        (pwm_pin)
    );

    assign flag_set = cap_stb || cmp_match;

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (flag_set) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    always_comb begin
        case (kind)
            K_CMP:   pin_out = cmp_pin;
            K_PWM:   pin_out = pwm_pin;
            default: pin_out = 1'b0;
        endcase
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = D_W'(ctrl_q);
            A_VLO:   rd_data = val_q[D_W-1:0];
            A_VHI:   rd_data = D_W'(val_q[T_W-1:D_W]);
            default: rd_data = '0;
        endcase
    end

    assign irq_flag = flag_q;
    assign sev_trig = cmp_trig;

    // R4
    val_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_stb && !(wr_en && (wr_addr == A_VLO || wr_addr == A_VHI))) |=> $stable(val_q));
    // R12
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !flag_set) |=> !irq_flag);
endmodule

// File: tb/ccp_channel_tb.sv
`timescale 1ns/1ps
module ccp_channel_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [1:0]  rd_addr;
    logic [7:0]  rd_data;
    logic        flag_clr;
    logic [15:0] tb_count;
    logic [7:0]  pwm_count;
    logic        pwm_period_start;
    logic        cap_in;
    logic        pin_out, irq_flag, sev_trig;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    localparam int PLEN = 64;

    always #4 clk = ~clk;

    ccp_channel u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .flag_clr(flag_clr), .tb_count(tb_count),
        .pwm_count(pwm_count), .pwm_period_start(pwm_period_start), .cap_in(cap_in),
        .pin_out(pin_out), .irq_flag(irq_flag), .sev_trig(sev_trig)
    );

    function automatic int pwm_high_exp(input int d);
        return (d == 0) ? 0 : ((d > PLEN) ? PLEN : d);
    endfunction

    function automatic bit div_due(input int e, input int div);
        return (e % div) == 0;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic chk_val(input string req, input logic [15:0] exp);
        logic [7:0] lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        chk(req, {hi, lo}, exp);
    endtask

    task automatic set_val(input logic [15:0] v);
        wr(2'd1, v[7:0]);
        wr(2'd2, v[15:8]);
    endtask

    task automatic clr;
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    task automatic edge_pulse(input logic [15:0] t);
        tb_count = t;
        cap_in = 1'b1;
        step(3);
        cap_in = 1'b0;
        step(3);
    endtask

    task automatic pwm_period(input bit mid, input logic [7:0] mid_b, output int highs);
        highs = 0;
        for (int k = 0; k < PLEN; k++) begin
            pwm_count = 8'(k / 4);
            pwm_period_start = (k == 0);
            if (mid && k == 20) begin
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = mid_b;
            end else begin
                wr_en = 1'b0;
            end
            step(1);
            if (pin_out) highs++;
        end
        wr_en = 1'b0;
        pwm_period_start = 1'b0;
        pwm_count = 8'd0;
    endtask

    task automatic set_duty(input int d, input logic [1:0] ml);
        wr(2'd1, 8'(d >> 2));
        wr(2'd0, {2'b00, 2'(d), 2'b11, ml});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v8;
        logic [15:0] t, t2, vv, expv;
        int          highs;
        bit          exp_pin;
        int          dl[4];

        void'($urandom(32'd2024));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        flag_clr = 1'b0; tb_count = '0; pwm_count = '0; pwm_period_start = 1'b0; cap_in = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v8);
            chk("R1 reg after reset", v8, 8'h00);
        end
        chk("R1 pin", pin_out, 0);
        chk("R1 flag", irq_flag, 0);
        chk("R1 trig", sev_trig, 0);

        // R2 register map
        wr(2'd0, 8'hFF);
        rd(2'd0, v8);
        chk("R2 ctrl upper bits read 0", v8, 8'h3F);
        wr(2'd1, 8'hA5);
        wr(2'd2, 8'h5A);
        rd(2'd1, v8); chk("R2 value low", v8, 8'hA5);
        rd(2'd2, v8); chk("R2 value high", v8, 8'h5A);
        rd(2'd3, v8); chk("R2 addr3", v8, 8'h00);
        wr(2'd0, 8'h00);

        // R4 rising and falling capture
        for (int i = 0; i < 4; i++) begin
            wr(2'd0, 8'h05);
            clr;
            t = 16'($urandom);
            tb_count = t; cap_in = 1'b1; step(3);
            chk_val("R4 rising capture", t);
            chk("R4 rising flag", irq_flag, 1);
            clr;
            tb_count = ~t; cap_in = 1'b0; step(3);
            chk_val("R4 falling ignored in rising mode", t);
            chk("R4 no flag on falling", irq_flag, 0);

            wr(2'd0, 8'h04);
            clr;
            t2 = 16'($urandom);
            tb_count = t2 ^ 16'h00F0; cap_in = 1'b1; step(3);
            chk_val("R4 rising ignored in falling mode", t);
            chk("R4 no flag on rising", irq_flag, 0);
            tb_count = t2; cap_in = 1'b0; step(3);
            chk_val("R4 falling capture", t2);
            chk("R4 falling flag", irq_flag, 1);
        end

        // R5 divide by 4
        wr(2'd0, 8'h06);
        clr;
        chk_val("R5 start", t2);
        expv = t2;
        for (int e = 1; e <= 8; e++) begin
            t = 16'($urandom);
            edge_pulse(t);
            if (div_due(e, 4)) expv = t;
            chk_val("R5 div4 value", expv);
            chk("R5 div4 flag", irq_flag, 32'(div_due(e, 4)));
            clr;
        end
        // R5 divide by 16
        wr(2'd0, 8'h07);
        clr;
        for (int e = 1; e <= 16; e++) begin
            t = 16'($urandom);
            edge_pulse(t);
            if (div_due(e, 16)) expv = t;
            if (e >= 15) begin
                chk_val("R5 div16 value", expv);
                chk("R5 div16 flag", irq_flag, 32'(div_due(e, 16)));
            end
        end
        // R5 restart on mode change
        wr(2'd0, 8'h06);
        clr;
        edge_pulse(16'h1111);
        edge_pulse(16'h2222);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h06);
        edge_pulse(16'h3333);
        edge_pulse(16'h4444);
        edge_pulse(16'h5555);
        chk_val("R5 count restarted", expv);
        chk("R5 no flag before 4th", irq_flag, 0);
        edge_pulse(16'h6666);
        chk_val("R5 4th after restart", 16'h6666);

        // R3 disabled and reserved codes
        dl[0] = 0; dl[1] = 1; dl[2] = 3; dl[3] = 0;
        for (int i = 0; i < 3; i++) begin
            wr(2'd0, 8'(dl[i]));
            vv = 16'h0800 + 16'(i);
            set_val(vv);
            tb_count = 16'h0000; step(1);
            clr;
            edge_pulse(16'($urandom));
            tb_count = vv; step(2);
            tb_count = 16'h0000;
            chk("R3 flag stays low", irq_flag, 0);
            chk("R3 pin low", pin_out, 0);
            chk("R3 no trig", sev_trig, 0);
            chk_val("R3 value kept", vv);
        end

        // R6 toggle compare, R9 single match per event
        vv = 16'h1234;
        tb_count = 16'h0000;
        set_val(vv);
        wr(2'd0, 8'h02);
        clr;
        chk("R6 pin initial", pin_out, 0);
        tb_count = vv; step(1);
        chk("R6 toggle high", pin_out, 1);
        chk("R6 flag", irq_flag, 1);
        step(3);
        chk("R9 held count no retoggle", pin_out, 1);
        clr;
        chk("R9 held count no new flag", irq_flag, 0);
        tb_count = vv + 16'd1; step(1);
        tb_count = vv; step(1);
        chk("R6 toggle low", pin_out, 0);
        chk("R6 flag again", irq_flag, 1);

        // R7 force modes
        wr(2'd0, 8'h09);
        chk("R7 enter 1001 drives high", pin_out, 1);
        tb_count = 16'h0000; step(1);
        clr;
        tb_count = vv; step(1);
        chk("R7 1001 match low", pin_out, 0);
        chk("R7 1001 flag", irq_flag, 1);
        tb_count = 16'h0000;
        wr(2'd0, 8'h08);
        chk("R7 enter 1000 drives low", pin_out, 0);
        clr;
        tb_count = vv; step(1);
        chk("R7 1000 match high", pin_out, 1);
        chk("R7 1000 flag", irq_flag, 1);

        // R8 flag-only and trigger modes
        wr(2'd0, 8'h0A);
        tb_count = 16'h0000; step(1);
        clr;
        tb_count = vv; step(1);
        chk("R8 1010 flag", irq_flag, 1);
        chk("R8 1010 pin unchanged", pin_out, 1);
        chk("R8 1010 no trig", sev_trig, 0);
        wr(2'd0, 8'h0B);
        tb_count = 16'h0000; step(1);
        clr;
        tb_count = vv; step(1);
        chk("R8 trig pulse", sev_trig, 1);
        chk("R8 trig flag", irq_flag, 1);
        step(1);
        chk("R8 trig one cycle", sev_trig, 0);

        // R12 set wins over clear
        tb_count = 16'h0000; step(1);
        clr;
        tb_count = vv; flag_clr = 1'b1; step(1);
        flag_clr = 1'b0;
        chk("R12 set beats clear", irq_flag, 1);
        clr;
        chk("R12 clear", irq_flag, 0);

        // R6 random toggles
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h02);
        exp_pin = 1'b0;
        for (int i = 0; i < 6; i++) begin
            vv = 16'($urandom);
            tb_count = vv + 16'd1;
            set_val(vv);
            step(1);
            tb_count = vv; step(1);
            exp_pin = ~exp_pin;
            chk("R6 random toggle", pin_out, 32'(exp_pin));
        end

        // R10 / R11 PWM
        wr(2'd0, 8'h00);
        dl[0] = 0; dl[1] = 1; dl[2] = 63; dl[3] = 64;
        for (int i = 0; i < 9; i++) begin
            int d;
            d = (i < 4) ? dl[i] : 2 + int'($urandom % 61);
            set_duty(d, 2'(i));
            pwm_period(1'b0, 8'h00, highs);
            pwm_period(1'b0, 8'h00, highs);
            if (d == 0) chk("R11 duty zero stays low", highs, 0);
            else        chk("R10 high cycles equal duty", highs, pwm_high_exp(d));
        end
        set_duty(40, 2'b00);
        pwm_period(1'b0, 8'h00, highs);
        pwm_period(1'b1, 8'd3, highs);
        chk("R10 mid-period write not applied", highs, 40);
        pwm_period(1'b0, 8'h00, highs);
        chk("R10 new duty next period", highs, 12);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule